// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire link to a single-channel serial converter. It drives an active-low chip select and a serial clock, and it takes in the converter's data line. The serial clock is divided down from the system clock. The block opens a frame, counts the serial clock edges, and shifts in the data bits. It then strips the leading zeros, presents the result right-aligned, and pulses a valid strobe. The converter drives its first leading zero when chip select falls. Every later falling edge of the serial clock shifts out one more bit.

Four static inputs set up the block: the clock divider, the frame length, the capture edge and the frame period. A full frame has sixteen clocks: four zeros, then twelve data bits with the MSB first. A short frame has twelve clocks: four zeros, then eight data bits. Capture on falling edges sees all four zeros. Capture on rising edges suits a slow serial clock; it misses the first zero and ignores the last rising edge. Frames start on a fixed grid. The grid spacing is the programmed period, raised where needed so that chip select stays high for the quiet time and the converter gets its full acquisition time. A sticky flag reports any frame whose checked leading zeros were not all zero.

Top module: `serial_adc_reader`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `cs_n` and `sclk` are high, and `res_valid` and `frm_err` are low.
- R2: The first frame starts on the first cycle after reset is released. In each frame `cs_n` is low for exactly 2·N·D cycles, where N is 16 (`cfg_short`=0) or 12 (`cfg_short`=1) and D is `cfg_div` (a value of 0 is taken as 1). `sclk` stays high for D cycles, then makes N low/high cycles of D cycles each. `cs_n` rises in the same cycle as the Nth rising edge of `sclk`, and `sclk` is high whenever `cs_n` is high.
- R3: With `cfg_rise_cap`=0, the data line is sampled just before each of the N falling edges of `sclk`. Bits 1..N arrive MSB first. Bits 1..4 are leading zeros and the rest are data.
- R4: With `cfg_rise_cap`=1, the data line is sampled at rising edges 1..N-1, which capture bits 2..N. Bit 1 is never seen and the Nth rising edge captures nothing.
- R5: A full frame gives the 12 data bits on `res_data[11:0]`. A short frame gives 8 data bits on `res_data[7:0]`, with `res_data[11:8]` at zero.
- R6: `res_valid` is high for exactly one cycle, the first cycle in which `cs_n` is high after a frame, and at no other time.
- R7: Frame starts (falls of `cs_n`) are spaced by E = max(`cfg_period`, 2·N·D + QUIET_CYC, 2·(N-1)·D + ACQ_CYC) cycles.
- R8: Between frames, `cs_n` stays high for at least QUIET_CYC cycles.
- R9: `frm_err` goes high with `res_valid` for a frame in which any captured leading-zero bit was 1. It stays high until reset. The data of that frame is still presented.
- R10: The level on `adc_sdata` while `cs_n` is high has no effect on the result or the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Serial clock half-period in system clocks (0 taken as 1) |
| cfg_short | input | 1 | 1 selects the 12-clock frame, 0 the 16-clock frame |
| cfg_rise_cap | input | 1 | 1 captures on rising serial clock edges, 0 on falling |
| cfg_period | input | PER_W | Requested frame period in system clocks |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdata | input | 1 | Serial data from the converter |
| res_data | output | 12 | Right-aligned conversion result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| frm_err | output | 1 | Sticky leading-zero error flag |

## Verification
Suppose the edge counter or the shift register slips by a single position. The next `res_valid` then shows a result shifted by one bit, or a false `frm_err`, which is one frame period after the fault at most. A wrong state in the period counter or the half-period counter shows up differently: the gap between two falls of `cs_n`, or the low time of `cs_n`, changes at the next frame boundary. A stray capture or strobe while `cs_n` is high becomes visible at once, because the bench holds the data line at 1 between frames and checks `res_valid` on every cycle.

// File: rtl/serial_adc_pkg.sv
// Shared constants and types for the serial ADC readout controller.
// Assumes the frame layout is four leading zeros, then data with the MSB first.
package serial_adc_pkg;
    localparam int FULL_CLKS  = 16;
    localparam int SHORT_CLKS = 12;
    localparam int LEAD_BITS  = 4;
    localparam int FULL_DATA  = FULL_CLKS - LEAD_BITS;
    localparam int SHORT_DATA = SHORT_CLKS - LEAD_BITS;
    localparam int RES_W      = FULL_DATA;
    localparam int CNT_W      = $clog2(FULL_CLKS + 1);

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_LOW  = 2'd2,
        SQ_HIGH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/serial_adc_frame_timer.sv
// Frame period timer: it issues one start pulse every E system clocks.
// E is the larger of the requested period and the minimum that the serial
// clock span, the quiet time and the acquisition time allow.
// Assumes the configuration is static while out of reset.
module serial_adc_frame_timer
    import serial_adc_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int PER_W     = 16,
    parameter int QUIET_CYC = 10,
    parameter int ACQ_CYC   = 45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_eff,
    input  logic             cfg_short,
    input  logic [PER_W-1:0] cfg_period,
    output logic             start
);
    localparam int SPAN_W = DIV_W + 8;
    localparam int CW     = (PER_W > SPAN_W ? PER_W : SPAN_W) + 1;

    logic [CW-1:0] d_w, n_w, span_a, span_b, min_per, eff_per;
    logic [CW-1:0] per_cnt;

    // Work out the minimum legal period and the period actually used.
    always_comb begin
        d_w     = CW'(div_eff);
        n_w     = cfg_short ? CW'(SHORT_CLKS) : CW'(FULL_CLKS);
        span_a  = ((n_w * d_w) << 1) + CW'(QUIET_CYC);
        span_b  = (((n_w - CW'(1)) * d_w) << 1) + CW'(ACQ_CYC);
        min_per = (span_a > span_b) ? span_a : span_b;
        eff_per = (CW'(cfg_period) > min_per) ? CW'(cfg_period) : min_per;
    end

    // Free-running period counter that wraps at E-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt <= '0;
        end else if (per_cnt >= eff_per - CW'(1)) begin
            per_cnt <= '0;
        end else begin
            per_cnt <= per_cnt + CW'(1);
        end
    end

    assign start = (per_cnt == '0);

    // The counter never leaves the range of the effective period.
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt < eff_per);
endmodule

// File: rtl/serial_adc_seq.sv
// Frame sequencer: it drives chip select and the serial clock, and marks
// each serial clock edge together with its 1-based index.
// Assumes a start pulse only arrives while idle, which the frame timer
// guarantees through its minimum period.
module serial_adc_seq
    import serial_adc_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int QUIET_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_eff,
    input  logic [CNT_W-1:0] n_clks,
    output logic             cs_n,
    output logic             sclk,
    output logic             fall_ev,
    output logic             rise_ev,
    output logic [CNT_W-1:0] edge_idx,
    output logic             frame_clr,
    output logic             frame_end
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    seq_state_t       st;
    logic [DIV_W-1:0] hc;
    logic [CNT_W-1:0] ecnt;
    logic             last_half;

    // Decode the events that happen at the next clock edge.
    always_comb begin
        last_half = (hc == div_eff - DIV_W'(1));
        fall_ev   = last_half && (st == SQ_LEAD || st == SQ_HIGH);
        rise_ev   = last_half && (st == SQ_LOW);
        frame_end = rise_ev && (ecnt == n_clks);
        frame_clr = (st == SQ_IDLE) && start;
        edge_idx  = (st == SQ_LOW) ? ecnt : ecnt + CNT_W'(1);
    end

    // State, half-period counter and edge counter of the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            cs_n <= 1'b1;
            sclk <= 1'b1;
            hc   <= '0;
            ecnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st   <= SQ_LEAD;
                        cs_n <= 1'b0;
                        hc   <= '0;
                        ecnt <= '0;
                    end
                end
                SQ_LEAD, SQ_HIGH: begin
                    if (last_half) begin
                        st   <= SQ_LOW;
                        sclk <= 1'b0;
                        hc   <= '0;
                        ecnt <= ecnt + CNT_W'(1);
                    end else begin
                        hc <= hc + DIV_W'(1);
                    end
                end
                SQ_LOW: begin
                    if (last_half) begin
                        sclk <= 1'b1;
                        hc   <= '0;
                        if (ecnt == n_clks) begin
                            st   <= SQ_IDLE;
                            cs_n <= 1'b1;
                        end else begin
                            st <= SQ_HIGH;
                        end
                    end else begin
                        hc <= hc + DIV_W'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Checker state: count the cycles chip select has been high.
    logic [QW-1:0] hi_cnt;
    logic          seen_frame;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (!cs_n) begin
                hi_cnt     <= '0;
                seen_frame <= 1'b1;
            end else if (hi_cnt < QW'(QUIET_CYC)) begin
                hi_cnt <= hi_cnt + QW'(1);
            end
        end
    end

    assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    assert_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt <= n_clks);
    assert_quiet_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seen_frame) |-> (hi_cnt >= QW'(QUIET_CYC)));
endmodule

// File: rtl/serial_adc_capture.sv
// Capture path: it shifts in data bits on the selected serial clock edge,
// checks the leading zeros, and registers the right-aligned result with a
// one-cycle strobe.
// Assumes frame_end coincides with the clock edge that raises chip select.
module serial_adc_capture
    import serial_adc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fall_ev,
    input  logic             rise_ev,
    input  logic [CNT_W-1:0] edge_idx,
    input  logic [CNT_W-1:0] n_clks,
    input  logic             frame_end,
    input  logic             cfg_short,
    input  logic             cfg_rise_cap,
    input  logic             sdata,
    output logic [RES_W-1:0] res_data,
    output logic             res_valid,
    output logic             frm_err
);
    logic [FULL_CLKS-1:0] sh;
    logic                 cap_en;
    logic [RES_W-1:0]     word;
    logic [LEAD_BITS-1:0] lead;
    logic                 lead_bad;

    // Pick the capture edge and split the shift register into fields.
    always_comb begin
        if (cfg_rise_cap) begin
            cap_en = rise_ev && (edge_idx < n_clks);
        end else begin
            cap_en = fall_ev;
        end
        if (cfg_short) begin
            word = {{(RES_W-SHORT_DATA){1'b0}}, sh[SHORT_DATA-1:0]};
            lead = sh[SHORT_CLKS-1:SHORT_DATA];
        end else begin
            word = sh[FULL_DATA-1:0];
            lead = sh[FULL_CLKS-1:FULL_DATA];
        end
        lead_bad = cfg_rise_cap ? (|lead[LEAD_BITS-2:0]) : (|lead);
    end

    // Shift register, result register, strobe and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            res_data  <= '0;
            res_valid <= 1'b0;
            frm_err   <= 1'b0;
        end else begin
            res_valid <= frame_end;
            if (clr) begin
                sh <= '0;
            end else if (cap_en) begin
                sh <= {sh[FULL_CLKS-2:0], sdata};
            end
            if (frame_end) begin
                res_data <= word;
                if (lead_bad) begin
                    frm_err <= 1'b1;
                end
            end
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> frm_err);
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cfg_short) |-> (res_data[RES_W-1:SHORT_DATA] == '0));
endmodule

// File: rtl/serial_adc_reader.sv
// Top of the serial ADC readout controller. It ties together the frame
// timer, the chip select / serial clock sequencer and the capture path.
// Assumes the cfg_* inputs stay constant while out of reset. Reset is
// synchronous and active low.
module serial_adc_reader
    import serial_adc_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int PER_W     = 16,
    parameter int QUIET_CYC = 10,
    parameter int ACQ_CYC   = 45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_short,
    input  logic             cfg_rise_cap,
    input  logic [PER_W-1:0] cfg_period,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    input  logic             adc_sdata,
    output logic [RES_W-1:0] res_data,
    output logic             res_valid,
    output logic             frm_err
);
    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] n_clks;
    logic             start, fall_ev, rise_ev, frame_clr, frame_end;
    logic [CNT_W-1:0] edge_idx;

    // Clamp the divider to at least 1 and derive the clock count per frame.
    always_comb begin
        div_eff = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
        n_clks  = cfg_short ? CNT_W'(SHORT_CLKS) : CNT_W'(FULL_CLKS);
    end

    serial_adc_frame_timer #(
        .DIV_W(DIV_W), .PER_W(PER_W), .QUIET_CYC(QUIET_CYC), .ACQ_CYC(ACQ_CYC)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .div_eff(div_eff), .cfg_short(cfg_short),
        .cfg_period(cfg_period), .start(start)
    );

    serial_adc_seq #(
        .DIV_W(DIV_W), .QUIET_CYC(QUIET_CYC)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .div_eff(div_eff),
        .n_clks(n_clks), .cs_n(adc_cs_n), .sclk(adc_sclk), .fall_ev(fall_ev),
        .rise_ev(rise_ev), .edge_idx(edge_idx), .frame_clr(frame_clr),
        .frame_end(frame_end)
    );

    serial_adc_capture i_cap (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr), .fall_ev(fall_ev),
        .rise_ev(rise_ev), .edge_idx(edge_idx), .n_clks(n_clks),
        .frame_end(frame_end), .cfg_short(cfg_short), .cfg_rise_cap(cfg_rise_cap),
        .sdata(adc_sdata), .res_data(res_data), .res_valid(res_valid),
        .frm_err(frm_err)
    );

    assert_no_capture_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_ev || rise_ev) |-> !adc_cs_n);
    assert_valid_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (adc_cs_n && !$past(adc_cs_n)));
endmodule

// File: tb/test_serial_adc_reader.sv
`timescale 1ns/1ps
// Bench: it sweeps frame length, capture edge, divider and period. A
// behavioural converter model drives the data line, and a monitor checks the
// timing and the results against values computed from the requirements.
module test_serial_adc_reader;
    localparam int DIV_W = 8, PER_W = 16, QUIET = 10, ACQ = 45, FRAMES = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_short = 1'b0, cfg_rise_cap = 1'b0;
    logic [PER_W-1:0] cfg_period = '0;
    logic             cs_n_w, sclk_w, res_valid, frm_err;
    logic             sdata_r = 1'b1;
    logic [11:0]      res_data;

    int checks = 0, errors = 0;
    int inj_frame = 0, seed = 0;
    int m_idx = 0, m_frame = 0;

    always #2.5 clk = ~clk;

    serial_adc_reader #(.DIV_W(DIV_W), .PER_W(PER_W), .QUIET_CYC(QUIET), .ACQ_CYC(ACQ))
    i_serial_adc_reader (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_short(cfg_short),
        .cfg_rise_cap(cfg_rise_cap), .cfg_period(cfg_period), .adc_cs_n(cs_n_w),
        .adc_sclk(sclk_w), .adc_sdata(sdata_r), .res_data(res_data),
        .res_valid(res_valid), .frm_err(frm_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nclk();
        return cfg_short ? 12 : 16;
    endfunction
    function automatic int deff();
        return (cfg_div == 0) ? 1 : int'(cfg_div);
    endfunction
    function automatic int eff_per();
        int a, b, m;
        a = 2 * nclk() * deff() + QUIET;
        b = 2 * (nclk() - 1) * deff() + ACQ;
        m = (a > b) ? a : b;
        return (int'(cfg_period) > m) ? int'(cfg_period) : m;
    endfunction
    function automatic int fval(input int f);
        int mask, v;
        mask = cfg_short ? 8'hFF : 12'hFFF;
        if (f == 1) v = 0;
        else if (f == 2) v = mask;
        else v = (f * 1103 + seed * 97 + 5) & mask;
        return v;
    endfunction
    function automatic logic bitval(input int i, input int f);
        if (i > nclk()) return 1'b0;
        if (i <= 4) return (i == 2 && f == inj_frame);
        return 1'(fval(f) >> (nclk() - i));
    endfunction

    // Converter model: chip select falling drives bit 1, each sclk fall the next.
    always @(negedge cs_n_w) if (rst_n) begin
        m_frame = m_frame + 1;
        m_idx = 1;
        sdata_r = bitval(1, m_frame);
    end
    always @(negedge sclk_w) if (rst_n && !cs_n_w) begin
        m_idx = m_idx + 1;
        sdata_r = bitval(m_idx, m_frame);
    end
    always @(posedge cs_n_w) sdata_r = 1'b1;   // floating line read as 1 (R10)

    // Monitor, sampling at the falling clock edge.
    int  cyc = 0, last_fall = 0, last_rise = 0, mon_f = 0, nfall = 0, done_f = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b1; mon_f = 0; nfall = 0; done_f = 0;
        end else begin
            if (prev_cs && !cs_n_w) begin
                if (mon_f > 0) begin
                    chk(cyc - last_fall == eff_per(), "R7 frame spacing", cyc - last_fall, eff_per());
                    chk(cyc - last_rise >= QUIET, "R8 quiet time", cyc - last_rise, QUIET);
                end
                mon_f++; last_fall = cyc; nfall = 0;
            end
            if (!cs_n_w && prev_sclk && !sclk_w) nfall++;
            if (res_valid && !(cs_n_w && !prev_cs))
                chk(1'b0, "R6 stray valid", 1, 0);
            if (!prev_cs && cs_n_w) begin
                int expe;
                last_rise = cyc;
                chk(cyc - last_fall == 2 * nclk() * deff(), "R2 cs low length", cyc - last_fall, 2 * nclk() * deff());
                chk(nfall == nclk(), "R2 sclk falling count", nfall, nclk());
                chk(res_valid == 1'b1, "R6 valid with cs rise", int'(res_valid), 1);
                // R3 / R4 / R5 / R10: data right-aligned, idle-line level ignored
                chk(int'(res_data) == fval(mon_f), cfg_rise_cap ? "R4 rising capture data" :
                    (cfg_short ? "R5 short data" : "R3 falling capture data"),
                    int'(res_data), fval(mon_f));
                expe = (inj_frame != 0 && mon_f >= inj_frame) ? 1 : 0;
                chk(int'(frm_err) == expe, "R9 framing error flag", int'(frm_err), expe);
                done_f = mon_f;
            end
            prev_cs = cs_n_w;
            prev_sclk = sclk_w;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 2; r++)
                for (int di = 0; di < 3; di++)
                    for (int p = 0; p < 2; p++) begin
                        @(negedge clk);
                        rst_n = 1'b0;
                        cfg_short = 1'(s); cfg_rise_cap = 1'(r);
                        cfg_div = (di == 0) ? 8'd0 : (di == 1) ? 8'd1 : 8'd3;
                        cfg_period = '0;
                        if (p == 1) cfg_period = PER_W'(eff_per() + 7);
                        inj_frame = (p == 1) ? 4 : 0;
                        seed = s * 12 + r * 6 + di * 2 + p;
                        m_frame = 0;
                        repeat (3) @(negedge clk);
                        // R1: reset state
                        chk(cs_n_w === 1'b1 && sclk_w === 1'b1, "R1 reset cs/sclk", int'({cs_n_w, sclk_w}), 3);
                        chk(res_valid === 1'b0 && frm_err === 1'b0, "R1 reset valid/err", int'({res_valid, frm_err}), 0);
                        rst_n = 1'b1;
                        @(negedge clk);
                        // R2: the first frame begins on the cycle after release
                        chk(cs_n_w === 1'b0, "R2 first frame start", int'(cs_n_w), 0);
                        while (done_f < FRAMES) @(negedge clk);
                        if (inj_frame != 0) begin
                            repeat (3) @(negedge clk);
                            chk(frm_err === 1'b1, "R9 error stays set", int'(frm_err), 1);
                        end
                    end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule